// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This block takes two IEEE single-precision operands and an operation code. It produces either a one-bit comparison result (equal, less-than, less-or-equal) or a 32-bit float that is the minimum or maximum of the pair. It also produces an invalid-operation flag. The decision logic is purely combinational. One output register holds the result and the flag, so the answer appears one clock after the operands and the operation code are presented.

The unit follows the minimumNumber/maximumNumber rules. A single NaN operand loses to the number. Two NaNs give one fixed quiet NaN. Negative zero sorts below positive zero. Equality is a quiet comparison, while the two ordered comparisons are signaling. Subnormal operands need no special path: they are ordered by their raw bit patterns, like every other non-NaN value.

Top module: `fcmp_minmax_unit`

## Requirements
- R1: For operation code 0 (equal), with neither operand NaN, the result is 1 when the operand bit patterns are identical or when both are zeros of any sign, and 0 otherwise.
- R2: For operation code 1 (less-than) and code 2 (less-or-equal), non-NaN operands are ordered by numeric value. Positive and negative zero are equal here, so less-than(-0,+0) is 0 and less-or-equal(-0,+0) is 1.
- R3: An operand is NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. It is quiet when bit 22 is set and signaling when bit 22 is clear. If either operand is NaN, operation codes 0, 1 and 2 return 0.
- R4: Less-than and less-or-equal raise invalid whenever either operand is a NaN, quiet or signaling.
- R5: Equal raises invalid only when an operand is a signaling NaN.
- R6: Operation code 3 (min) returns the smaller operand and code 4 (max) returns the larger one, bit-exact. Negative zero counts as strictly less than positive zero.
- R7: When both operands are NaN, min and max return exactly 0x7fc00000.
- R8: When exactly one operand is NaN, min and max return the other operand unchanged. Invalid is raised for min and max only if an operand is a signaling NaN.
- R9: A comparison result occupies bit 0 of the result port, and bits 31:1 are zero.
- R10: Operation codes 5, 6 and 7 give a result of 0 and invalid 0.
- R11: The result and the flag are registered. They reflect the inputs sampled at the previous rising clock edge, and both read 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 eq, 1 lt, 2 le, 3 min, 4 max |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Comparison bit in bit 0, or min/max value |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench sweeps every ordered pair drawn from a set of boundary values under all eight operation codes. The values include signed zeros, the smallest and largest subnormals, normals, infinities, and quiet and signaling NaNs with several payloads. Ordering the magnitudes the same way for negative operands as for positive ones would put -1.5 above -1.0 and reverse the order of negative subnormals. Treating the two zeros as unequal would break equal and less-or-equal, while treating them as equal in min/max would let +0 win a minimum. Passing a NaN payload through, or picking the NaN instead of the number, would show as a wrong 32-bit result. Swapping the quiet and signaling flag rules between equal and the ordered comparisons would show on the invalid output.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_LT  = 3'd1,
        OP_LE  = 3'd2,
        OP_MIN = 3'd3,
        OP_MAX = 3'd4
    } fcmp_op_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } fcmp_class_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] x,
    output fcmp_class_t          cls
);
    localparam int W = EXP_W + MAN_W + 1;

    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    always_comb begin
        exp_ones    = &x[W-2:MAN_W];
        exp_zero    = ~|x[W-2:MAN_W];
        frac_nz     = |x[MAN_W-1:0];
        cls.sign    = x[W-1];
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~x[MAN_W-1];
        cls.is_zero = exp_zero & ~frac_nz;
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_below_b,
    output logic         same_bits
);
    logic mag_lt;
    logic mag_gt;

    always_comb begin
        mag_lt    = a[W-2:0] < b[W-2:0];
        mag_gt    = a[W-2:0] > b[W-2:0];
        same_bits = (a == b);
        if (a[W-1] != b[W-1]) begin
            a_below_b = a[W-1];
        end else if (a[W-1]) begin
            a_below_b = mag_gt;
        end else begin
            a_below_b = mag_lt;
        end
    end

endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [2:0]           op,
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  fcmp_class_t          ca,
    input  fcmp_class_t          cb,
    input  logic                 a_below_b,
    input  logic                 same_bits,
    output logic [EXP_W+MAN_W:0] res,
    output logic                 inv
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic any_nan;
    logic any_snan;
    logic both_zero;
    logic eq_val;
    logic lt_val;

    always_comb begin
        any_nan   = ca.is_nan | cb.is_nan;
        any_snan  = ca.is_snan | cb.is_snan;
        both_zero = ca.is_zero & cb.is_zero;
        eq_val    = ~any_nan & (same_bits | both_zero);
        lt_val    = ~any_nan & a_below_b & ~both_zero;
        res       = '0;
        inv       = 1'b0;
        case (op)
            OP_EQ: begin
                res[0] = eq_val;
                inv    = any_snan;
            end
            OP_LT: begin
                res[0] = lt_val;
                inv    = any_nan;
            end
            OP_LE: begin
                res[0] = lt_val | eq_val;
                inv    = any_nan;
            end
            OP_MIN, OP_MAX: begin
                inv = any_snan;
                if (ca.is_nan && cb.is_nan) begin
                    res = CANON_NAN;
                end else if (ca.is_nan) begin
                    res = b;
                end else if (cb.is_nan) begin
                    res = a;
                end else if (op == OP_MIN) begin
                    res = a_below_b ? a : b;
                end else begin
                    res = a_below_b ? b : a;
                end
            end
            default: begin
                res = '0;
                inv = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fcmp_minmax_unit.sv
module fcmp_minmax_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op,
    input  logic [EXP_W+MAN_W:0] opa,
    input  logic [EXP_W+MAN_W:0] opb,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 invalid
);
    localparam int W = EXP_W + MAN_W + 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         inv;
    } out_t;

    logic [W-1:0] opnd [2];
    fcmp_class_t  cls  [2];
    logic         a_below_b;
    logic         same_bits;
    logic [W-1:0] sel_res;
    logic         sel_inv;
    out_t         st_d;
    out_t         st_q;

    assign opnd[0] = opa;
    assign opnd[1] = opb;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .x  (opnd[g]),
            .cls(cls[g])
        );
    end

    fcmp_order #(.W(W)) u_order (
        .a        (opa),
        .b        (opb),
        .a_below_b(a_below_b),
        .same_bits(same_bits)
    );

    fcmp_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
        .op       (op),
        .a        (opa),
        .b        (opb),
        .ca       (cls[0]),
        .cb       (cls[1]),
        .a_below_b(a_below_b),
        .same_bits(same_bits),
        .res      (sel_res),
        .inv      (sel_inv)
    );

    always_comb begin
        st_d.res = sel_res;
        st_d.inv = sel_inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign invalid = st_q.inv;

endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           op,
    input logic [EXP_W+MAN_W:0] opa,
    input logic [EXP_W+MAN_W:0] opb,
    input logic [EXP_W+MAN_W:0] result,
    input logic                 invalid
);
    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] CANON =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_sig, b_sig, is_cmp, is_mm, is_ord;

    always_comb begin
        a_nan  = (opa[W-2:MAN_W] == {EXP_W{1'b1}}) && (opa[MAN_W-1:0] != '0);
        b_nan  = (opb[W-2:MAN_W] == {EXP_W{1'b1}}) && (opb[MAN_W-1:0] != '0);
        a_sig  = a_nan && !opa[MAN_W-1];
        b_sig  = b_nan && !opb[MAN_W-1];
        is_cmp = (op <= 3'd2);
        is_ord = (op == 3'd1) || (op == 3'd2);
        is_mm  = (op == 3'd3) || (op == 3'd4);
    end

    // R3: NaN operand forces a zero comparison
    p_nan_cmp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_cmp && (a_nan || b_nan)) |-> result == '0);

    // R4: ordered comparisons signal on any NaN
    p_ord_nan_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_ord && (a_nan || b_nan)) |-> invalid);

    // R5: equality stays quiet without a signaling NaN
    p_eq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op == 3'd0 && !a_sig && !b_sig) |-> !invalid);

    // R7: two NaNs give the canonical NaN
    p_canon_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_mm && a_nan && b_nan) |-> result == CANON);

    // R8: one NaN yields the other operand
    p_one_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_mm && a_nan && !b_nan) |-> result == $past(opb));

    // R9: comparison results use bit 0 only
    p_cmp_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_cmp) |-> result[W-1:1] == '0);

    // R10: unused codes are inert
    p_unused_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op > 3'd4) |-> (result == '0 && !invalid));

endmodule

bind fcmp_minmax_unit fcmp_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .invalid(invalid)
);

// File: tb/tb_fcmp_minmax_unit.sv
module tb_fcmp_minmax_unit;

    localparam int NV = 20;
    localparam logic [31:0] CANON = 32'h7fc00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        invalid;

    int checks = 0;
    int errors = 0;
    logic [31:0] vals [NV];

    always #2.5 clk = ~clk;

    fcmp_minmax_unit dut (
        .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
        .result(result), .invalid(invalid)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    function automatic real to_real(logic [31:0] x);
        real mag;
        int e;
        e = int'(x[30:23]);
        if (e == 255) mag = 1.0e300;
        else if (e == 0) mag = real'(x[22:0]) * (2.0 ** (-149));
        else mag = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return x[31] ? -mag : mag;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, op, opa, opb, act, exp_v);
        end
    endtask

    task automatic run_one(int o, logic [31:0] a, logic [31:0] b);
        logic [31:0] er;
        logic ei;
        bit an, bn, anyn, anys;
        real ra, rb;
        string tr, ti;
        @(negedge clk);
        op  = 3'(o);
        opa = a;
        opb = b;
        an = is_nan(a); bn = is_nan(b);
        anyn = an || bn;
        anys = is_snan(a) || is_snan(b);
        ra = to_real(a); rb = to_real(b);
        er = '0; ei = 1'b0;
        case (o)
            0: begin er[0] = !anyn && (ra == rb); ei = anys;
                     tr = anyn ? "R3" : "R1,R9"; ti = "R5"; end
            1: begin er[0] = !anyn && (ra < rb); ei = anyn;
                     tr = anyn ? "R3" : "R2,R9"; ti = "R4"; end
            2: begin er[0] = !anyn && (ra <= rb); ei = anyn;
                     tr = anyn ? "R3" : "R2,R9"; ti = "R4"; end
            3, 4: begin
                ei = anys; ti = "R8";
                if (an && bn) begin er = CANON; tr = "R7"; end
                else if (an) begin er = b; tr = "R8"; end
                else if (bn) begin er = a; tr = "R8"; end
                else if (ra == rb) begin
                    tr = "R6";
                    if (o == 3) er = a[31] ? a : b;
                    else er = a[31] ? b : a;
                end else begin
                    tr = "R6";
                    if (o == 3) er = (ra < rb) ? a : b;
                    else er = (ra < rb) ? b : a;
                end
            end
            default: begin tr = "R10"; ti = "R10"; end
        endcase
        @(negedge clk);
        check(tr, result, er);
        check(ti, {31'b0, invalid}, {31'b0, ei});
    endtask

    initial begin
        vals[0]  = 32'h00000000; vals[1]  = 32'h80000000;
        vals[2]  = 32'h00000001; vals[3]  = 32'h80000001;
        vals[4]  = 32'h007fffff; vals[5]  = 32'h807fffff;
        vals[6]  = 32'h3f800000; vals[7]  = 32'hbf800000;
        vals[8]  = 32'h3fc00000; vals[9]  = 32'hbfc00000;
        vals[10] = 32'h7f7fffff; vals[11] = 32'hff7fffff;
        vals[12] = 32'h7f800000; vals[13] = 32'hff800000;
        vals[14] = 32'h7fc00000; vals[15] = 32'hffc12345;
        vals[16] = 32'h7f800001; vals[17] = 32'hffa00000;
        vals[18] = 32'h00800000; vals[19] = 32'h3f800000;

        // R11: outputs cleared during reset even with live inputs
        op = 3'd1; opa = 32'h7fc00000; opb = 32'h3f800000;
        repeat (3) @(negedge clk);
        check("R11", result, 32'h0);
        check("R11", {31'b0, invalid}, 32'h0);
        rst_n = 1'b1;

        for (int o = 0; o < 8; o++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    run_one(o, vals[i], vals[j]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule